// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is the programming front end of a two-channel frequency synthesizer. A host shifts a fixed-length word into it over three wires: serial data, serial clock and latch enable. On each rising edge of the serial clock one bit enters a shift register. The most significant bit is sent first, so the newest bit always lands at bit 0. All three wires are asynchronous to the system clock. They pass through synchronizers, and their edges are detected in the system clock domain.

When latch enable rises, the two least-significant bits of the word select where it goes. These are the last two bits shifted in. A word can go to one of four destinations:
- the reference-divider register of channel 0 or channel 1, which holds a 14-bit ratio, two test bits and a pump-current select bit;
- the main/swallow divider register of channel 0 or channel 1, which holds an 11-bit main count N and a 7-bit swallow count A.

The selected register updates and its own one-cycle strobe pulses. A word whose ratio or main count is below 3 is dropped. A dropped word changes no register, fires no strobe and sets a sticky error flag.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset, every register output is zero, no strobe is active and `err_o` is 0.
- R2: Each synchronized rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 of a 24-bit shift register. The word is sent MSB first. Only the last 24 bits shifted before latch enable rises take effect; earlier bits are lost.
- R3: On a rising edge of `ser_le_i`, word bits [1:0] pick the destination. 0 is the channel 0 reference register, 1 is the channel 1 reference register, 2 is the channel 0 divider register, and 3 is the channel 1 divider register.
- R4: Reference word layout: ratio in bits [15:2], test bits in [17:16], pump-current select in bit 18. Bits [23:19] are ignored.
- R5: Divider word layout: A in bits [8:2], N in bits [19:9]. Bits [23:20] are ignored.
- R6: An accepted load raises `upd_o[code]` for exactly one system clock cycle. This happens in the same cycle the new value appears at the outputs. No other strobe fires, and no register changes without its strobe.
- R7: A reference word with a ratio below 3 is rejected. No register changes, no strobe fires, and `err_o` is set.
- R8: A divider word with N below 3 is rejected in the same way, and `err_o` is set.
- R9: `err_o` stays at 1 until reset, including across later accepted loads.
- R10: Shifting alone, without a rising edge on latch enable, changes no output.
- R11: The limit values are accepted: ratio 3 and 16383, N 3 and 2047, A 0 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le_i | input | 1 | Latch enable; rising edge commits the word |
| ref_ratio_o | output | 2×14 | Reference divide ratio per channel |
| ref_test_o | output | 2×2 | Test bits per channel |
| ref_cps_o | output | 2 | Pump-current select per channel |
| div_n_o | output | 2×11 | Main count N per channel |
| div_a_o | output | 2×7 | Swallow count A per channel |
| upd_o | output | 4 | One-cycle update strobe, indexed by destination code |
| err_o | output | 1 | Sticky error flag for a rejected load |

## Verification
Directed words are sent to each of the four codes, each with a distinct field pattern. This shows whether the control bits steer a word to the right register and whether each field sits at its own bit position. Limit values and values just below the minimum separate the accept path from the reject path. Two further cases isolate the shift and latch timing: an over-long word whose leading bits must drop out, and a shift sequence with no latch pulse. A run of random words with random codes and occasional out-of-range values then compares every output and every strobe count against a bench model.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int WORD_W    = 24;
  localparam int CTRL_W    = 2;
  localparam int NUM_CH    = 2;
  localparam int NUM_DEST  = 2 * NUM_CH;
  localparam int RATIO_W   = 14;
  localparam int RATIO_LSB = CTRL_W;
  localparam int TEST_W    = 2;
  localparam int TEST_LSB  = RATIO_LSB + RATIO_W;
  localparam int CPS_BIT   = TEST_LSB + TEST_W;
  localparam int A_W       = 7;
  localparam int A_LSB     = CTRL_W;
  localparam int N_W       = 11;
  localparam int N_LSB     = A_LSB + A_W;
  localparam int MIN_RATIO = 3;
  localparam int MIN_N     = 3;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [TEST_W-1:0]  test;
    logic               cps;
  } ref_word_t;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } div_word_t;
endpackage

// File: rtl/ldr_sync_edge.sv
module ldr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ldr_shifter.sv
module ldr_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/ldr_decode.sv
module ldr_decode
  import ldr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [CTRL_W-1:0] dest,
  output logic              is_ref,
  output ref_word_t         ref_w,
  output div_word_t         div_w,
  output logic              ref_ok,
  output logic              div_ok
);
  always_comb begin
    dest        = word[CTRL_W-1:0];
    is_ref      = (int'(dest) < NUM_CH);
    ref_w.ratio = word[RATIO_LSB +: RATIO_W];
    ref_w.test  = word[TEST_LSB +: TEST_W];
    ref_w.cps   = word[CPS_BIT];
    div_w.n     = word[N_LSB +: N_W];
    div_w.a     = word[A_LSB +: A_W];
    ref_ok      = (ref_w.ratio >= RATIO_W'(MIN_RATIO));
    div_ok      = (div_w.n >= N_W'(MIN_N));
  end
endmodule

// File: rtl/ldr_chan_regs.sv
module ldr_chan_regs
  import ldr_pkg::*;
#(
  parameter logic [CTRL_W-1:0] REF_CODE = '0,
  parameter logic [CTRL_W-1:0] DIV_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CTRL_W-1:0] dest,
  input  ref_word_t         ref_in,
  input  div_word_t         div_in,
  input  logic              ref_ok,
  input  logic              div_ok,
  output ref_word_t         ref_q,
  output div_word_t         div_q,
  output logic              ref_upd,
  output logic              div_upd
);
  logic ref_take, div_take;
  assign ref_take = load && (dest == REF_CODE) && ref_ok;
  assign div_take = load && (dest == DIV_CODE) && div_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= '0;
      div_q   <= '0;
      ref_upd <= 1'b0;
      div_upd <= 1'b0;
    end else begin
      ref_upd <= ref_take;
      div_upd <= div_take;
      if (ref_take) ref_q <= ref_in;
      if (div_take) div_q <= div_in;
    end
  end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import ldr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             ser_clk_i,
  input  logic                             ser_data_i,
  input  logic                             ser_le_i,
  output logic [NUM_CH-1:0][RATIO_W-1:0]   ref_ratio_o,
  output logic [NUM_CH-1:0][TEST_W-1:0]    ref_test_o,
  output logic [NUM_CH-1:0]                ref_cps_o,
  output logic [NUM_CH-1:0][N_W-1:0]       div_n_o,
  output logic [NUM_CH-1:0][A_W-1:0]       div_a_o,
  output logic [NUM_DEST-1:0]              upd_o,
  output logic                             err_o
);
  logic sclk_lvl, sclk_rise;
  logic sdat_lvl, sdat_rise;
  logic le_lvl, le_rise;

  ldr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .din(ser_clk_i), .level(sclk_lvl), .rise(sclk_rise));
  ldr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .din(ser_data_i), .level(sdat_lvl), .rise(sdat_rise));
  ldr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst(rst), .din(ser_le_i), .level(le_lvl), .rise(le_rise));

  logic [WORD_W-1:0] word;
  ldr_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(sdat_lvl), .word(word));

  logic [CTRL_W-1:0] dest;
  logic              is_ref, ref_ok, div_ok;
  ref_word_t         ref_w;
  div_word_t         div_w;

  ldr_decode u_dec (
    .word(word), .dest(dest), .is_ref(is_ref), .ref_w(ref_w), .div_w(div_w),
    .ref_ok(ref_ok), .div_ok(div_ok));

  ref_word_t ref_q [NUM_CH];
  div_word_t div_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ldr_chan_regs #(
      .REF_CODE(CTRL_W'(ch)),
      .DIV_CODE(CTRL_W'(NUM_CH + ch))
    ) u_regs (
      .clk(clk), .rst(rst), .load(le_rise), .dest(dest),
      .ref_in(ref_w), .div_in(div_w), .ref_ok(ref_ok), .div_ok(div_ok),
      .ref_q(ref_q[ch]), .div_q(div_q[ch]),
      .ref_upd(upd_o[ch]), .div_upd(upd_o[NUM_CH + ch]));

    assign ref_ratio_o[ch] = ref_q[ch].ratio;
    assign ref_test_o[ch]  = ref_q[ch].test;
    assign ref_cps_o[ch]   = ref_q[ch].cps;
    assign div_n_o[ch]     = div_q[ch].n;
    assign div_a_o[ch]     = div_q[ch].a;
  end

  logic bad_load;
  assign bad_load = le_rise && (is_ref ? !ref_ok : !div_ok);

  always_ff @(posedge clk) begin
    if (rst)           err_o <= 1'b0;
    else if (bad_load) err_o <= 1'b1;
  end

  logic unused_ok;
  assign unused_ok = ^{sclk_lvl, sdat_rise, le_lvl};
endmodule

// File: rtl/ldr_checks.sv
module ldr_checks
  import ldr_pkg::*;
(
  input logic                           clk,
  input logic                           rst,
  input logic                           le_rise,
  input logic [NUM_DEST-1:0]            upd,
  input logic                           err,
  input logic [NUM_CH-1:0][RATIO_W-1:0] ref_ratio,
  input logic [NUM_CH-1:0][N_W-1:0]     div_n
);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst) $onehot0(upd));

  p_strobe_after_le_r10: assert property (@(posedge clk) disable iff (rst)
    (|upd) |-> $past(le_rise));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst) err |=> err);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_ref_change_strobed_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(ref_ratio[ch]) |-> upd[ch]);
    p_div_change_strobed_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(div_n[ch]) |-> upd[NUM_CH + ch]);
    p_ratio_legal_r7: assert property (@(posedge clk) disable iff (rst)
      upd[ch] |-> (ref_ratio[ch] >= RATIO_W'(MIN_RATIO)));
    p_n_legal_r8: assert property (@(posedge clk) disable iff (rst)
      upd[NUM_CH + ch] |-> (div_n[ch] >= N_W'(MIN_N)));
  end
endmodule

bind synth_serial_loader ldr_checks u_chk (
  .clk(clk), .rst(rst), .le_rise(le_rise), .upd(upd_o), .err(err_o),
  .ref_ratio(ref_ratio_o), .div_n(div_n_o));

// File: tb/synth_serial_loader_tb.sv
`timescale 1ns/1ps
module synth_serial_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [1:0][13:0] ref_ratio;
  logic [1:0][1:0]  ref_test;
  logic [1:0]       ref_cps;
  logic [1:0][10:0] div_n;
  logic [1:0][6:0]  div_a;
  logic [3:0]       upd;
  logic             err;

  always #2.5 clk = ~clk;

  synth_serial_loader u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_le_i(ser_le),
    .ref_ratio_o(ref_ratio), .ref_test_o(ref_test), .ref_cps_o(ref_cps),
    .div_n_o(div_n), .div_a_o(div_a), .upd_o(upd), .err_o(err));

  int checks = 0, fails = 0;
  int cnt [4];
  int ecnt [4];
  int e_ratio [2], e_test [2], e_cps [2], e_n [2], e_a [2];
  int e_err;
  bit done = 0;

  initial for (int k = 0; k < 4; k++) begin cnt[k] = 0; ecnt[k] = 0; end

  always @(negedge clk) if (!rst) for (int k = 0; k < 4; k++) if (upd[k]) cnt[k]++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 2; c++) begin
      chk(req, $sformatf("ratio[%0d]", c), int'(ref_ratio[c]), e_ratio[c]);
      chk(req, $sformatf("test[%0d]", c),  int'(ref_test[c]),  e_test[c]);
      chk(req, $sformatf("cps[%0d]", c),   int'(ref_cps[c]),   e_cps[c]);
      chk(req, $sformatf("n[%0d]", c),     int'(div_n[c]),     e_n[c]);
      chk(req, $sformatf("a[%0d]", c),     int'(div_a[c]),     e_a[c]);
    end
    for (int k = 0; k < 4; k++) chk(req, $sformatf("strobes[%0d]", k), cnt[k], ecnt[k]);
    chk(req, "err", int'(err), e_err);
  endtask

  function automatic logic [23:0] mk_ref(int ch, int ratio, int test, int cps, int fill);
    logic [23:0] w = '0;
    w[1:0] = 2'(ch); w[15:2] = 14'(ratio); w[17:16] = 2'(test);
    w[18] = 1'(cps); w[23:19] = 5'(fill);
    return w;
  endfunction

  function automatic logic [23:0] mk_div(int ch, int n, int a, int fill);
    logic [23:0] w = '0;
    w[1:0] = 2'(2 + ch); w[8:2] = 7'(a); w[19:9] = 11'(n); w[23:20] = 4'(fill);
    return w;
  endfunction

  task automatic model(input logic [23:0] w);
    int code = int'(w[1:0]);
    if (code < 2) begin
      if (int'(w[15:2]) >= 3) begin
        e_ratio[code] = int'(w[15:2]); e_test[code] = int'(w[17:16]);
        e_cps[code] = int'(w[18]); ecnt[code]++;
      end else e_err = 1;
    end else begin
      if (int'(w[19:9]) >= 3) begin
        e_n[code-2] = int'(w[19:9]); e_a[code-2] = int'(w[8:2]); ecnt[code]++;
      end else e_err = 1;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_data = v[i]; wait_clk(3);
      ser_clk = 1'b1;  wait_clk(3);
      ser_clk = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; wait_clk(4);
    ser_le = 1'b0; wait_clk(8);
  endtask

  task automatic load(input logic [23:0] w);
    shift_bits({8'h00, w}, 24); pulse_le(); model(w);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wait_clk(4); rst = 1'b0; wait_clk(2);
    for (int c = 0; c < 2; c++) begin
      e_ratio[c] = 0; e_test[c] = 0; e_cps[c] = 0; e_n[c] = 0; e_a[c] = 0;
    end
    e_err = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [23:0] w;
    seed = $urandom(32'd2024);
    do_reset();
    check_all("R1");

    load(mk_ref(0, 3, 2, 1, 31));      check_all("R11 R4 R3 ratio=3 ch0");
    load(mk_ref(1, 16383, 1, 0, 0));   check_all("R11 R4 R3 ratio=16383 ch1");
    load(mk_div(0, 3, 127, 15));       check_all("R11 R5 R3 n=3 a=127 ch0");
    load(mk_div(1, 2047, 0, 0));       check_all("R11 R5 R3 n=2047 a=0 ch1");
    load(mk_div(0, 1234, 85, 9));      check_all("R5 R6 ch0 mid");

    shift_bits({8'h00, mk_ref(0, 777, 3, 0, 0)}, 24);
    check_all("R10 shift without latch");
    pulse_le(); model(mk_ref(0, 777, 3, 0, 0));
    check_all("R10 latch after shift");

    w = mk_ref(1, 4321, 2, 1, 5);
    shift_bits({8'hA5, w}, 30); pulse_le(); model(w);
    check_all("R2 over-long word");

    load(mk_ref(1, 2, 0, 0, 0));       check_all("R7 ratio=2 rejected");
    load(mk_div(1, 500, 3, 0));        check_all("R9 err stays after good load");

    do_reset();
    check_all("R1 second reset");
    load(mk_div(0, 2, 5, 0));          check_all("R8 n=2 rejected");
    load(mk_div(1, 0, 0, 0));          check_all("R8 n=0 rejected");
    load(mk_ref(0, 100, 0, 1, 0));     check_all("R9 err held");

    do_reset();
    for (int i = 0; i < 40; i++) begin
      int code = int'($urandom % 4);
      bool_bad: begin end
      if (code < 2) begin
        int r = ($urandom % 8 == 0) ? int'($urandom % 3) : 3 + int'($urandom % 16381);
        w = mk_ref(code, r, int'($urandom % 4), int'($urandom % 2), int'($urandom % 32));
      end else begin
        int n = ($urandom % 8 == 0) ? int'($urandom % 3) : 3 + int'($urandom % 2045);
        w = mk_div(code - 2, n, int'($urandom % 128), int'($urandom % 16));
      end
      load(w);
      check_all("R3 R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule